// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

The block generates a bit-serial keystream from three linear feedback shift registers of 19, 22 and 23 bits. A one-cycle start request captures a 64-bit session key and a 22-bit public frame number. The block then clears its registers and runs a fixed load sequence. A warm-up follows whose output is thrown away. After that it streams a burst of 228 keystream bits. Each burst bit comes with a one-cycle valid strobe, and a done pulse marks the end of the burst.

The load and the warm-up run on their own with no handshake. During the load every register shifts on every cycle. After the load the registers move in stop/go fashion. Each register has one clocking bit, and a register shifts only when that bit agrees with the majority vote of the three clocking bits. A caller that supplies a plaintext bit together with its own valid receives the ciphertext bit in the same cycle as the keystream bit.

Top module: `ksg_top`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, ks_valid_o, ks_bit_o, done_o and ct_valid_o are all 0.
- R2: The registers are A (19 bits), B (22 bits) and C (23 bits). Each shift writes the feedback into bit 0 and moves every other bit up by one. The feedback is the XOR of the tap bits, which are A{13,16,17,18}, B{20,21} and C{7,20,21,22}. Each keystream bit is A[18] XOR B[21] XOR C[22], taken after the step that makes it.
- R3: A start accepted in idle clears all three registers. For 64 cycles all three registers then shift, with key_i bit n (LSB first) XORed into every feedback on cycle n. For 22 more cycles frame_i is loaded the same way, LSB first.
- R4: After the load come 100 majority-controlled steps with no output. The first ks_valid_o is high exactly 187 clock edges after the edge that accepts the start.
- R5: Exactly 228 keystream bits are produced, one per cycle on consecutive cycles, and ks_valid_o is high only while busy_o is high.
- R6: done_o is high for exactly one cycle, on the cycle after the 228th valid bit. busy_o falls on that same cycle.
- R7: A start_i raised while busy_o is high has no effect on the running burst. The keystream keeps the values of the first key and frame.
- R8: ct_valid_o = pt_valid_i AND ks_valid_o. While ct_valid_o is high, ct_bit_o = pt_bit_i XOR ks_bit_o.
- R9: In the warm-up and burst steps, the clocking bits A[8], B[10] and C[10] are compared with their majority. Only the registers whose bit matches shift, so at least two registers move on every step.
- R10: An all-zero key together with an all-zero frame gives an all-zero keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only in idle |
| key_i | input | 64 | Session key, captured on start |
| frame_i | input | 22 | Frame number, captured on start |
| pt_valid_i | input | 1 | Plaintext bit valid |
| pt_bit_i | input | 1 | Plaintext bit |
| busy_o | output | 1 | A sequence is running |
| ks_valid_o | output | 1 | Keystream bit valid strobe |
| ks_bit_o | output | 1 | Keystream bit |
| ct_valid_o | output | 1 | Ciphertext bit valid |
| ct_bit_o | output | 1 | Ciphertext bit |
| done_o | output | 1 | One-cycle pulse after the last keystream bit |

## Verification
The bench builds the block with its default widths and lengths: a 64-bit key, a 22-bit frame, a 100-step warm-up and a 228-bit burst. With these values the full 415-cycle sequence fits in a few hundred cycles per frame, so every keystream bit of several complete bursts is compared with a bench model. Burst start, burst length and the done pulse are checked on their exact cycles, and a start request is injected partway through the load.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  localparam int N_REG = 3;
  localparam int REG_LEN  [N_REG] = '{19, 22, 23};
  localparam int CLK_POS  [N_REG] = '{8, 10, 10};
  localparam logic [31:0] TAP_MASK [N_REG] = '{32'h0007_2000, 32'h0030_0000, 32'h0070_0080};

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_KEY,
    PH_FRAME,
    PH_WARM,
    PH_RUN,
    PH_FIN
  } phase_e;
endpackage

// File: rtl/ksg_lfsr.sv
module ksg_lfsr #(
  parameter int          LEN      = 19,
  parameter logic [31:0] TAP_MASK = 32'h0007_2000,
  parameter int          CLK_POS  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic inj_i,
  output logic clk_bit_o,
  output logic msb_next_o
);
  localparam logic [LEN-1:0] MASK = TAP_MASK[LEN-1:0];

  logic [LEN-1:0] q;
  logic           fb;

  assign fb         = (^(q & MASK)) ^ inj_i;
  assign clk_bit_o  = q[CLK_POS];
  assign msb_next_o = shift_i ? q[LEN-2] : q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clear_i) q <= '0;
    else if (shift_i) q <= {q[LEN-2:0], fb};
  end
endmodule

// File: rtl/ksg_clk_ctrl.sv
module ksg_clk_ctrl #(
  parameter int N = 3
) (
  input  logic         regular_i,
  input  logic         irregular_i,
  input  logic [N-1:0] cbits_i,
  output logic [N-1:0] shift_o
);
  logic maj;

  assign maj = (cbits_i[0] & cbits_i[1]) | (cbits_i[0] & cbits_i[2]) | (cbits_i[1] & cbits_i[2]);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      shift_o[i] = regular_i | (irregular_i & (cbits_i[i] == maj));
    end
  end
endmodule

// File: rtl/ksg_seq.sv
module ksg_seq
  import ksg_pkg::*;
#(
  parameter int KEY_W     = 64,
  parameter int FRAME_W   = 22,
  parameter int WARM_CYC  = 100,
  parameter int BURST_LEN = 228
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output phase_e             phase_o,
  output logic               clear_o,
  output logic               inj_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int MAX_A = (KEY_W > FRAME_W) ? KEY_W : FRAME_W;
  localparam int MAX_B = (WARM_CYC > BURST_LEN) ? WARM_CYC : BURST_LEN;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [KEY_W-1:0]   key_q;
  logic [FRAME_W-1:0] frame_q;
  logic               last;

  assign phase_o = phase;
  assign busy_o  = (phase != PH_IDLE);
  assign clear_o = (phase == PH_IDLE) && start_i;
  assign inj_o   = (phase == PH_KEY)   ? key_q[0]   :
                   (phase == PH_FRAME) ? frame_q[0] : 1'b0;

  always_comb begin
    unique case (phase)
      PH_KEY:   last = (cnt == CNT_W'(KEY_W - 1));
      PH_FRAME: last = (cnt == CNT_W'(FRAME_W - 1));
      PH_WARM:  last = (cnt == CNT_W'(WARM_CYC - 1));
      PH_RUN:   last = (cnt == CNT_W'(BURST_LEN - 1));
      default:  last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      key_q   <= '0;
      frame_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start_i) begin
          phase   <= PH_KEY;
          cnt     <= '0;
          key_q   <= key_i;
          frame_q <= frame_i;
        end
        PH_FIN: begin
          phase  <= PH_IDLE;
          done_o <= 1'b1;
        end
        default: begin
          if (phase == PH_KEY)   key_q   <= {1'b0, key_q[KEY_W-1:1]};
          if (phase == PH_FRAME) frame_q <= {1'b0, frame_q[FRAME_W-1:1]};
          if (last) begin
            cnt <= '0;
            unique case (phase)
              PH_KEY:   phase <= PH_FRAME;
              PH_FRAME: phase <= PH_WARM;
              PH_WARM:  phase <= PH_RUN;
              default:  phase <= PH_FIN;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(MAX_C));

  // R6
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE && phase != PH_FIN && start_i) |=>
      (phase != PH_KEY || $past(phase) == PH_KEY));
endmodule

// File: rtl/ksg_top.sv
module ksg_top
  import ksg_pkg::*;
#(
  parameter int KEY_W     = 64,
  parameter int FRAME_W   = 22,
  parameter int WARM_CYC  = 100,
  parameter int BURST_LEN = 228
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               pt_valid_i,
  input  logic               pt_bit_i,
  output logic               busy_o,
  output logic               ks_valid_o,
  output logic               ks_bit_o,
  output logic               ct_valid_o,
  output logic               ct_bit_o,
  output logic               done_o
);
  phase_e           phase;
  logic             clear;
  logic             inj;
  logic [N_REG-1:0] cbits;
  logic [N_REG-1:0] shift_en;
  logic [N_REG-1:0] msb_next;
  logic             run_step;

  ksg_seq #(
    .KEY_W(KEY_W), .FRAME_W(FRAME_W), .WARM_CYC(WARM_CYC), .BURST_LEN(BURST_LEN)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i), .frame_i(frame_i),
    .phase_o(phase), .clear_o(clear), .inj_o(inj), .busy_o(busy_o), .done_o(done_o)
  );

  ksg_clk_ctrl #(.N(N_REG)) u_clk (
    .regular_i  (phase == PH_KEY || phase == PH_FRAME),
    .irregular_i(phase == PH_WARM || phase == PH_RUN),
    .cbits_i    (cbits),
    .shift_o    (shift_en)
  );

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    ksg_lfsr #(
      .LEN(REG_LEN[g]), .TAP_MASK(TAP_MASK[g]), .CLK_POS(CLK_POS[g])
    ) u_lfsr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .shift_i(shift_en[g]),
      .inj_i(inj), .clk_bit_o(cbits[g]), .msb_next_o(msb_next[g])
    );
  end

  assign run_step = (phase == PH_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ks_valid_o <= 1'b0;
      ks_bit_o   <= 1'b0;
    end else begin
      ks_valid_o <= run_step;
      ks_bit_o   <= run_step & (^msb_next);
    end
  end

  assign ct_valid_o = pt_valid_i & ks_valid_o;
  assign ct_bit_o   = ct_valid_o & (pt_bit_i ^ ks_bit_o);

  // R9
  maj_two_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WARM || phase == PH_RUN) |-> $countones(shift_en) >= 2);

  // R3
  load_all_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_KEY || phase == PH_FRAME) |-> (&shift_en));

  // R5
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o |-> busy_o);
endmodule

// File: tb/ksg_tb.sv
module ksg_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  FIRST_K    = 187;
  localparam int  NBITS      = 228;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] key_i = '0;
  logic [21:0] frame_i = '0;
  logic        pt_valid_i = 1'b0;
  logic        pt_bit_i = 1'b0;
  logic        busy_o, ks_valid_o, ks_bit_o, ct_valid_o, ct_bit_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_ks [NBITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  ksg_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i), .frame_i(frame_i),
    .pt_valid_i(pt_valid_i), .pt_bit_i(pt_bit_i), .busy_o(busy_o), .ks_valid_o(ks_valid_o),
    .ks_bit_o(ks_bit_o), .ct_valid_o(ct_valid_o), .ct_bit_o(ct_bit_o), .done_o(done_o)
  );

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_run(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    logic        in_b, m, sa, sb, sc;
    a = '0; b = '0; c = '0;
    for (int i = 0; i < 86; i++) begin
      in_b = (i < 64) ? k[i] : f[i-64];
      a = {a[17:0], a[13] ^ a[16] ^ a[17] ^ a[18] ^ in_b};
      b = {b[20:0], b[20] ^ b[21] ^ in_b};
      c = {c[21:0], c[7] ^ c[20] ^ c[21] ^ c[22] ^ in_b};
    end
    for (int i = 0; i < 100 + NBITS; i++) begin
      m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
      sa = (a[8] == m); sb = (b[10] == m); sc = (c[10] == m);
      if (sa) a = {a[17:0], a[13] ^ a[16] ^ a[17] ^ a[18]};
      if (sb) b = {b[20:0], b[20] ^ b[21]};
      if (sc) c = {c[21:0], c[7] ^ c[20] ^ c[21] ^ c[22]};
      if (i >= 100) exp_ks[i-100] = a[18] ^ b[21] ^ c[22];
    end
  endtask

  task automatic run_frame(input logic [63:0] k, input logic [21:0] f, input logic poke);
    int  n_valid;
    logic ev;
    ref_run(k, f);
    n_valid = 0;
    @(negedge clk);
    key_i = k; frame_i = f; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R3", "busy after start", busy_o, 1);
    for (int kk = 1; kk <= 420; kk++) begin
      @(negedge clk);
      ev = (kk >= FIRST_K) && (kk < FIRST_K + NBITS);
      pt_valid_i = 1'($urandom);
      pt_bit_i   = 1'($urandom);
      if (poke && kk == 50) begin
        start_i = 1'b1; key_i = ~k; frame_i = ~f;
      end else begin
        start_i = 1'b0;
      end
      #1;
      // R4 / R5: valid only in the burst window
      chk(ks_valid_o == ev, "R4", $sformatf("valid at cycle %0d", kk), ks_valid_o, ev);
      if (ev) begin
        n_valid++;
        // R2, R3, R7, R10
        chk(ks_bit_o == exp_ks[kk-FIRST_K], poke ? "R7" : "R2",
            $sformatf("ks bit %0d", kk-FIRST_K), ks_bit_o, exp_ks[kk-FIRST_K]);
      end
      // R8
      chk(ct_valid_o == (pt_valid_i & ev), "R8", "ct_valid", ct_valid_o, pt_valid_i & ev);
      if (ev && pt_valid_i)
        chk(ct_bit_o == (pt_bit_i ^ exp_ks[kk-FIRST_K]), "R8", "ct bit", ct_bit_o,
            pt_bit_i ^ exp_ks[kk-FIRST_K]);
      // R6
      chk(done_o == (kk == FIRST_K + NBITS), "R6", $sformatf("done at %0d", kk), done_o,
          kk == FIRST_K + NBITS);
      chk(busy_o == (kk < FIRST_K + NBITS), "R6", $sformatf("busy at %0d", kk), busy_o,
          kk < FIRST_K + NBITS);
    end
    start_i = 1'b0; pt_valid_i = 1'b0;
    // R5
    chk(n_valid == NBITS, "R5", "burst length", n_valid, NBITS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic all_zero;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    chk({busy_o, ks_valid_o, ks_bit_o, done_o, ct_valid_o} == 5'b0, "R1", "outputs in reset",
        {busy_o, ks_valid_o, ks_bit_o, done_o, ct_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy_o, ks_valid_o, ks_bit_o, done_o, ct_valid_o} == 5'b0, "R1", "outputs after reset",
        {busy_o, ks_valid_o, ks_bit_o, done_o, ct_valid_o}, 0);

    // R10: zero key and frame
    run_frame(64'h0, 22'h0, 1'b0);
    all_zero = 1'b1;
    for (int i = 0; i < NBITS; i++) if (exp_ks[i]) all_zero = 1'b0;
    chk(all_zero, "R10", "model zero stream", all_zero, 1);

    // R3: single key bit and single frame bit exercise ordering
    run_frame(64'h1, 22'h0, 1'b0);
    run_frame(64'h8000_0000_0000_0000, 22'h20_0000, 1'b0);
    run_frame(64'hFFFF_FFFF_FFFF_FFFF, 22'h3F_FFFF, 1'b0);

    // R2: random sessions
    for (int r = 0; r < 4; r++) begin
      run_frame({$urandom, $urandom}, 22'($urandom), 1'b0);
    end

    // R7: start during load ignored
    run_frame({$urandom, $urandom}, 22'($urandom), 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule